// File: doc/BRIEF.md
# Galois Pseudo-Random Sequence Generator with Run-Time Taps

This block produces a pseudo-random bit pattern from an internal-feedback shift register of parameterised length `WIDTH`. The most significant stage is the feedback bit. Each cycle, it is folded into every stage whose coefficient bit is set, through an XOR placed between that stage and the one below it. The tap set is not fixed in hardware: a coefficient vector on a port selects which XOR paths are active. One build of the block can therefore run any polynomial of its length. Choosing a primitive polynomial is the caller's job.

A seed is written with a one-cycle strobe and becomes both the current state and the stored reference value. Stepping happens only on enabled cycles. A registered `period_done` pulse marks every step that brings the register back to the stored seed, which signals that a full period has been completed. An all-zero seed would freeze the register, so the block refuses it. In that case it loads the all-ones pattern and flags the event for one cycle.

Top module: `galois_prng`

## Requirements
- R1: A synchronous active-high `rst` sets `state_q` and the stored seed to all-ones and clears `period_done` and `seed_err`, with effect from the clock edge at which it is sampled.
- R2: On an enabled step, with f = `state_q[WIDTH-1]`, the new stage 0 equals `coef[0]` AND f. For each k from 1 to WIDTH-1, the new stage k equals old stage k-1 XOR (`coef[k]` AND f). The top coefficient g_n is always 1 and has no port bit.
- R3: When neither `seed_vld` nor `step_en` is high, `state_q` keeps its value.
- R4: `seed_vld` loads `seed_val` into `state_q` and into the stored seed whether or not `step_en` is high, and it wins over stepping.
- R5: A load with `seed_val` equal to zero puts all-ones into `state_q` and the stored seed, and raises `seed_err` for exactly that one cycle.
- R6: `period_done` is high for one cycle, aligned with `state_q`, exactly when an enabled step has produced a state equal to the stored seed. It is never high after a load or a hold.
- R7: With WIDTH=3, `coef`=3'b011 and seed 3'b111, the steps give 3'b101 and then 3'b001, and the register returns to 3'b111 on the seventh step.
- R8: With a primitive coefficient set (WIDTH=8, `coef`=8'h1D), the register never shows zero, and `period_done` first fires on step 2^WIDTH−1 = 255.
- R9: Different coefficient vectors produce different successors. With WIDTH=3 and state 3'b111, `coef`=3'b101 gives 3'b011, while 3'b011 gives 3'b101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the register by one step |
| seed_vld | input | 1 | Load strobe for `seed_val` |
| seed_val | input | WIDTH | Seed value |
| coef | input | WIDTH | Feedback coefficients g0..g(n-1), one bit per stage |
| state_q | output | WIDTH | Current register state (registered) |
| period_done | output | 1 | One-cycle pulse when a step returns to the stored seed |
| seed_err | output | 1 | One-cycle pulse when an all-zero seed was replaced |

## Verification
The no-lockup property assumes that `coef[0]` is 1 on the steps it covers, because a zero constant coefficient makes the map non-invertible and lets the state reach zero. That property is therefore guarded by `coef[0]`. The stimulus always sets that bit while stepping and holds `coef` steady during each measured period. The period and done checks also assume the coefficients stay unchanged between a seed load and the return to that seed. Every scenario keeps to this.

// File: rtl/galois_prng_pkg.sv
package galois_prng_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2,
    ACT_FIX  = 2'd3
  } prng_act_e;

endpackage

// File: rtl/galois_step.sv
module galois_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] coef,
  output logic [WIDTH-1:0] nxt
);

  logic fb;
  assign fb = cur[WIDTH-1];

  assign nxt[0] = coef[0] & fb;

  for (genvar k = 1; k < WIDTH; k++) begin : g_stage
    assign nxt[k] = cur[k-1] ^ (coef[k] & fb);
  end

endmodule

// File: rtl/seed_guard.sv
module seed_guard #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seed_vld,
  input  logic [WIDTH-1:0] seed_val,
  output logic             seed_zero,
  output logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] seed_q
);

  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  assign seed_zero = (seed_val == '0);
  assign load_val  = seed_zero ? ONES : seed_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      seed_q <= ONES;
    end else if (seed_vld) begin
      seed_q <= load_val;
    end
  end

  AST_SEED_NONZERO: assert property (@(posedge clk) disable iff (rst)
    seed_vld |=> (seed_q != '0)); // R5

endmodule

// File: rtl/period_flag.sv
module period_flag #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stepping,
  input  logic [WIDTH-1:0] nxt,
  input  logic [WIDTH-1:0] seed_q,
  output logic             done_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
    end else begin
      done_q <= stepping && (nxt == seed_q);
    end
  end

endmodule

// File: rtl/galois_prng.sv
module galois_prng
  import galois_prng_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             seed_vld,
  input  logic [WIDTH-1:0] seed_val,
  input  logic [WIDTH-1:0] coef,
  output logic [WIDTH-1:0] state_q,
  output logic             period_done,
  output logic             seed_err
);

  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] load_val;
  logic [WIDTH-1:0] seed_q;
  logic             seed_zero;
  logic             stepping;
  prng_act_e        act;

  galois_step #(.WIDTH(WIDTH)) u_step (
    .cur  (state_q),
    .coef (coef),
    .nxt  (nxt)
  );

  seed_guard #(.WIDTH(WIDTH)) u_guard (
    .clk       (clk),
    .rst       (rst),
    .seed_vld  (seed_vld),
    .seed_val  (seed_val),
    .seed_zero (seed_zero),
    .load_val  (load_val),
    .seed_q    (seed_q)
  );

  always_comb begin
    if (seed_vld)     act = seed_zero ? ACT_FIX : ACT_LOAD;
    else if (step_en) act = ACT_STEP;
    else              act = ACT_HOLD;
  end

  assign stepping = (act == ACT_STEP);

  period_flag #(.WIDTH(WIDTH)) u_flag (
    .clk      (clk),
    .rst      (rst),
    .stepping (stepping),
    .nxt      (nxt),
    .seed_q   (seed_q),
    .done_q   (period_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ONES;
      seed_err <= 1'b0;
    end else begin
      seed_err <= (act == ACT_FIX);
      case (act)
        ACT_LOAD, ACT_FIX: state_q <= load_val;
        ACT_STEP:          state_q <= nxt;
        default:           state_q <= state_q;
      endcase
    end
  end

  AST_RESET_ONES: assert property (@(posedge clk)
    rst |=> (state_q == ONES) && !period_done && !seed_err); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!seed_vld && !step_en) |=> $stable(state_q)); // R3

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (seed_vld && seed_val != '0) |=> (state_q == $past(seed_val)) && !seed_err); // R4

  AST_ZERO_SEED_FIX: assert property (@(posedge clk) disable iff (rst)
    (seed_vld && seed_val == '0) |=> (state_q == ONES) && seed_err); // R5

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(seed_err) |-> $past(seed_vld)); // R5

  AST_DONE_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    (seed_vld || !step_en) |=> !period_done); // R6

  AST_DONE_AT_SEED: assert property (@(posedge clk) disable iff (rst)
    period_done |-> (state_q == seed_q)); // R6

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
    (step_en && !seed_vld && coef[0] && state_q != '0) |=> (state_q != '0)); // R8

endmodule

// File: tb/sim_galois_prng.sv
module sim_galois_prng;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       en0 = 1'b0, sv0 = 1'b0;
  logic [7:0] sd0 = '0,   cf0 = 8'h1D;
  logic [7:0] st0;
  logic       dn0, er0;

  logic       en1 = 1'b0, sv1 = 1'b0;
  logic [2:0] sd1 = '0,   cf1 = 3'b011;
  logic [2:0] st1;
  logic       dn1, er1;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  galois_prng #(.WIDTH(8)) u0 (
    .clk(clk), .rst(rst), .step_en(en0), .seed_vld(sv0), .seed_val(sd0),
    .coef(cf0), .state_q(st0), .period_done(dn0), .seed_err(er0));

  galois_prng #(.WIDTH(3)) u1 (
    .clk(clk), .rst(rst), .step_en(en1), .seed_vld(sv1), .seed_val(sd1),
    .coef(cf1), .state_q(st1), .period_done(dn1), .seed_err(er1));

  function automatic logic [7:0] ref_next(logic [7:0] s, logic [7:0] c, int n);
    logic [7:0] r;
    logic f;
    f = s[n-1];
    r = '0;
    r[0] = c[0] & f;
    for (int k = 1; k < n; k++) r[k] = s[k-1] ^ (c[k] & f);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1; en0 = 0; sv0 = 0; en1 = 0; sv1 = 0;
    tick();
    @(negedge clk); rst = 1'b0;
    chk("R1 state u0", st0, 8'hFF);
    chk("R1 state u1", st1, 3'b111);
    chk("R1 done", {dn0, dn1}, 0);
    chk("R1 err", {er0, er1}, 0);
  endtask

  task automatic t_example();
    @(negedge clk); cf1 = 3'b011; sd1 = 3'b111; sv1 = 1; en1 = 1;
    tick();
    chk("R4 load", st1, 3'b111);
    chk("R6 no done on load", dn1, 0);
    @(negedge clk); sv1 = 0;
    tick(); chk("R7 step1", st1, 3'b101);
    tick(); chk("R7 step2", st1, 3'b001);
    for (int i = 3; i <= 7; i++) begin
      tick();
      if (i < 7) chk("R6 no early done", dn1, 0);
    end
    chk("R7 period 7", st1, 3'b111);
    chk("R6 done at seed", dn1, 1);
    tick();
    chk("R6 done one cycle", dn1, 0);
    chk("R2 continue", st1, 3'b101);
    @(negedge clk); en1 = 0;
  endtask

  task automatic t_hold();
    logic [2:0] keep;
    tick();
    keep = st1;
    tick(); tick();
    chk("R3 hold", st1, keep);
    chk("R6 no done on hold", dn1, 0);
  endtask

  task automatic t_priority();
    @(negedge clk); sd1 = 3'b110; sv1 = 1; en1 = 1;
    tick();
    chk("R4 load beats step", st1, 3'b110);
    @(negedge clk); sd1 = 3'b010; en1 = 0;
    tick();
    chk("R4 load without enable", st1, 3'b010);
    @(negedge clk); sv1 = 0;
  endtask

  task automatic t_zero_seed();
    @(negedge clk); sd1 = 3'b000; sv1 = 1; en1 = 0;
    tick();
    chk("R5 ones loaded", st1, 3'b111);
    chk("R5 err raised", er1, 1);
    @(negedge clk); sv1 = 0; en1 = 1; cf1 = 3'b011;
    tick();
    chk("R5 err one cycle", er1, 0);
    for (int i = 2; i <= 7; i++) tick();
    chk("R5 stored seed is ones", {st1, dn1}, {3'b111, 1'b1});
    @(negedge clk); en1 = 0;
  endtask

  task automatic t_coef();
    @(negedge clk); sd1 = 3'b111; sv1 = 1; cf1 = 3'b101;
    tick();
    @(negedge clk); sv1 = 0; en1 = 1;
    tick();
    chk("R9 coef 101 successor", st1, 3'b011);
    @(negedge clk); en1 = 0;
  endtask

  task automatic t_max();
    logic [7:0] model;
    int first_done = -1;
    bit saw_zero = 0;
    @(negedge clk); cf0 = 8'h1D; sd0 = 8'h01; sv0 = 1;
    tick();
    model = 8'h01;
    @(negedge clk); sv0 = 0; en0 = 1;
    for (int i = 1; i <= 255; i++) begin
      tick();
      model = ref_next(model, cf0, 8);
      if (st0 !== model) chk("R2 step match", st0, model);
      if (st0 == 8'h00) saw_zero = 1;
      if (dn0 && first_done < 0) first_done = i;
    end
    chk("R2 sequence end", st0, model);
    chk("R8 never zero", saw_zero, 0);
    chk("R8 period 255", first_done, 255);
    @(negedge clk); en0 = 0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_example();
    t_hold();
    t_priority();
    t_zero_seed();
    t_coef();
    t_max();
    t_reset();
    finish_run();
  end

endmodule